// File: doc/BRIEF.md
# Transactional Line Footprint Conflict Tracker

This block follows the memory footprint of one hardware transaction and decides, when the transaction finishes, whether its buffered effects may be published or must be thrown away. The core reports five kinds of event, each with an address: begin, load, store, end and explicit abort. Tracking is per 64-byte line. A load marks its line as read, and a store marks its line as written. Both marks live in a small fully associative table of line tags.

At the same time the block watches a snoop port, which carries reads and writes made by other agents. It flags a conflict in three cases: an outside write hits any tracked line, an outside read hits a line this transaction has written, or the table has no room for a new line. Conflicts and capacity overflow are remembered as a pending cause. The outermost end then turns into a one-cycle abort pulse carrying that cause, or into a one-cycle commit pulse if nothing went wrong. Data values are never compared, so a write of an unchanged value still conflicts. Nested begins only deepen a counter.

Top module: `txn_footprint_tracker`

## Requirements
- R1: After reset, txn_active_o, commit_o and abort_o are low, abort_cause_o is 0 and nest_depth_o is 0.
- R2: core_op_i uses these codes: 0 begin, 1 load, 2 store, 3 end, 4 abort; other codes do nothing. Address bits [5:0] are ignored, so any two addresses in the same 64-byte line share one table entry.
- R3: While a transaction is active, an outside write (snoop_write_i=1) to a line the transaction has loaded makes the outermost end produce abort_o with cause 1 (conflict) instead of a commit. The written value plays no part.
- R4: An outside write or read to a line the transaction has stored to gives cause 1. An outside read to a line that was only loaded has no effect.
- R5: An outermost end with no pending cause raises commit_o for exactly one cycle, in the cycle after the end is sampled, with abort_cause_o 0. commit_o and abort_o are never high together.
- R6: The table holds 8 lines. A load or store to a ninth distinct line makes the outermost end abort with cause 2 (capacity). Touching exactly 8 lines, at any offsets within them, still commits.
- R7: An abort event during an active transaction raises abort_o with cause 3 in the next cycle, whatever the nesting depth, and leaves the block inactive at depth 0.
- R8: While no transaction is active, load, store, end, abort and snoop events produce no pulse and are not tracked. A later outside write to a line loaded while idle does not conflict.
- R9: A begin while active increments nest_depth_o, which saturates at 7. An end at a depth above 1 decrements it and produces no verdict. Only the end that brings the depth to 0 produces a verdict.
- R10: The table and the pending cause are cleared at every verdict and at every outermost begin, so lines from an earlier transaction never conflict in a later one.
- R11: A snoop is compared against the table as it stood before that cycle's core event. A conflicting snoop in the same cycle as the outermost end still aborts. The first pending cause is kept: a conflict followed by a capacity overflow reports cause 1.
- R12: Outside writes or reads to lines not in the table have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_valid_i | input | 1 | A core event is present this cycle |
| core_op_i | input | 3 | Core event code (0 begin, 1 load, 2 store, 3 end, 4 abort) |
| core_addr_i | input | ADDR_W | Byte address of a load or store |
| snoop_valid_i | input | 1 | An access by another agent is present |
| snoop_write_i | input | 1 | 1 when the outside access is a write, 0 for a read |
| snoop_addr_i | input | ADDR_W | Byte address of the outside access |
| txn_active_o | output | 1 | A transaction is open |
| nest_depth_o | output | NEST_W | Current nesting depth |
| commit_o | output | 1 | One-cycle commit pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause_o | output | 2 | Cause that goes with abort_o (1 conflict, 2 capacity, 3 explicit), otherwise 0 |

## Verification
All results are registered once. An event sampled on one rising edge shows on commit_o, abort_o, abort_cause_o, txn_active_o and nest_depth_o right after that edge, and a pulse lasts only that one cycle. The bench applies each event half a cycle before the capturing edge and reads the outputs on the falling edge that follows it. Every verdict is therefore checked in the single cycle where it is due, and the pulse's absence is checked one event later. Conflicts do not surface until the outermost end, so the bench also checks that no pulse appears right after a conflicting snoop.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;

    // Reported abort causes; the numeric values are visible at the ports.
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_CONFLICT = 2'd1,
        CAUSE_CAPACITY = 2'd2,
        CAUSE_EXPLICIT = 2'd3
    } abort_cause_e;

    // Core-side event codes.
    typedef enum logic [2:0] {
        OP_BEGIN = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_END   = 3'd3,
        OP_ABORT = 3'd4
    } core_op_e;

endpackage

// File: rtl/txn_line_match.sv
// Compares one line tag against every valid table entry in parallel.
module txn_line_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 26,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);

    logic [ENTRIES-1:0] eq;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq[g] = vld_i[g] && (tag_i[g] == key_i);
        end
    endgenerate

    always_comb begin
        hit_o = |eq;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/txn_free_pick.sv
// Chooses the lowest unused table slot and reports when none is left.
module txn_free_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] vld_i,
    output logic               full_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        full_o = &vld_i;
        idx_o  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/txn_line_table.sv
// Storage for tracked lines: tag, valid, read mark, write mark per slot.
module txn_line_table #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 26,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          upd_i,
    input  logic                          alloc_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [TAG_W-1:0]              tag_i,
    input  logic                          mark_rd_i,
    input  logic                          mark_wr_i,
    output logic [ENTRIES-1:0]            vld_o,
    output logic [ENTRIES-1:0]            rd_o,
    output logic [ENTRIES-1:0]            wr_o,
    output logic [ENTRIES-1:0][TAG_W-1:0] tag_o
);

    logic [ENTRIES-1:0]            vld_d, vld_q;
    logic [ENTRIES-1:0]            rd_d,  rd_q;
    logic [ENTRIES-1:0]            wr_d,  wr_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_d, tag_q;

    always_comb begin
        vld_d = vld_q;
        rd_d  = rd_q;
        wr_d  = wr_q;
        tag_d = tag_q;
        if (clear_i) begin
            vld_d = '0;
            rd_d  = '0;
            wr_d  = '0;
        end else if (upd_i) begin
            if (alloc_i) begin
                vld_d[idx_i] = 1'b1;
                tag_d[idx_i] = tag_i;
                rd_d[idx_i]  = mark_rd_i;
                wr_d[idx_i]  = mark_wr_i;
            end else begin
                rd_d[idx_i]  = rd_q[idx_i] | mark_rd_i;
                wr_d[idx_i]  = wr_q[idx_i] | mark_wr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
            tag_q <= '0;
        end else begin
            vld_q <= vld_d;
            rd_q  <= rd_d;
            wr_q  <= wr_d;
            tag_q <= tag_d;
        end
    end

    assign vld_o = vld_q;
    assign rd_o  = rd_q;
    assign wr_o  = wr_q;
    assign tag_o = tag_q;

endmodule

// File: rtl/txn_footprint_tracker.sv
// Read/write set tracker for one transaction, with a verdict at the outermost end.
module txn_footprint_tracker
    import txn_trk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    parameter int ENTRIES  = 8,
    parameter int NEST_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid_i,
    input  logic [2:0]        core_op_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic              snoop_valid_i,
    input  logic              snoop_write_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    output logic              txn_active_o,
    output logic [NEST_W-1:0] nest_depth_o,
    output logic              commit_o,
    output logic              abort_o,
    output logic [1:0]        abort_cause_o
);

    localparam int TAG_W = ADDR_W - LINE_OFS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [NEST_W-1:0] DEPTH_MAX = {NEST_W{1'b1}};
    localparam logic [NEST_W-1:0] DEPTH_ONE = NEST_W'(1);

    typedef struct packed {
        logic [NEST_W-1:0] depth;
        abort_cause_e      pend;
        logic              commit;
        logic              abort;
        abort_cause_e      cause;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Line tags: the offset bits inside a line take no part.
    logic [TAG_W-1:0] core_tag, snp_tag;
    logic [2*LINE_OFS-1:0] unused_ofs;
    assign core_tag   = core_addr_i[ADDR_W-1:LINE_OFS];
    assign snp_tag    = snoop_addr_i[ADDR_W-1:LINE_OFS];
    assign unused_ofs = {core_addr_i[LINE_OFS-1:0], snoop_addr_i[LINE_OFS-1:0]};

    // Table state and control.
    logic [ENTRIES-1:0]            ent_vld, ent_rd, ent_wr;
    logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
    logic                          tbl_clear, tbl_upd, tbl_alloc;
    logic [IDX_W-1:0]              tbl_idx;
    logic                          mark_rd, mark_wr;

    logic             core_hit, snp_hit, tbl_full;
    logic [IDX_W-1:0] core_idx, snp_idx, free_idx;
    logic             active, snp_conflict;
    logic [ENTRIES-1:0] unused_rd;

    assign unused_rd = ent_rd;

    txn_line_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tbl_clear),
        .upd_i     (tbl_upd),
        .alloc_i   (tbl_alloc),
        .idx_i     (tbl_idx),
        .tag_i     (core_tag),
        .mark_rd_i (mark_rd),
        .mark_wr_i (mark_wr),
        .vld_o     (ent_vld),
        .rd_o      (ent_rd),
        .wr_o      (ent_wr),
        .tag_o     (ent_tag)
    );

    txn_line_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_core_match (
        .vld_i (ent_vld),
        .tag_i (ent_tag),
        .key_i (core_tag),
        .hit_o (core_hit),
        .idx_o (core_idx)
    );

    txn_line_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snoop_match (
        .vld_i (ent_vld),
        .tag_i (ent_tag),
        .key_i (snp_tag),
        .hit_o (snp_hit),
        .idx_o (snp_idx)
    );

    txn_free_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
        .vld_i  (ent_vld),
        .full_o (tbl_full),
        .idx_o  (free_idx)
    );

    assign active = (ctl_q.depth != '0);

    // Outside writes hit either set; outside reads hit only the write set.
    assign snp_conflict = active && snoop_valid_i && snp_hit &&
                          (snoop_write_i || ent_wr[snp_idx]);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.commit = 1'b0;
        ctl_d.abort  = 1'b0;
        ctl_d.cause  = CAUSE_NONE;
        tbl_clear    = 1'b0;
        tbl_upd      = 1'b0;
        tbl_alloc    = 1'b0;
        tbl_idx      = core_idx;
        mark_rd      = 1'b0;
        mark_wr      = 1'b0;

        if (snp_conflict && ctl_q.pend == CAUSE_NONE) begin
            ctl_d.pend = CAUSE_CONFLICT;
        end

        if (core_valid_i) begin
            case (core_op_i)
                OP_BEGIN: begin
                    if (!active) begin
                        ctl_d.depth = DEPTH_ONE;
                        ctl_d.pend  = CAUSE_NONE;
                        tbl_clear   = 1'b1;
                    end else if (ctl_q.depth != DEPTH_MAX) begin
                        ctl_d.depth = ctl_q.depth + DEPTH_ONE;
                    end
                end
                OP_LOAD, OP_STORE: begin
                    if (active) begin
                        mark_rd = (core_op_i == OP_LOAD);
                        mark_wr = (core_op_i == OP_STORE);
                        if (core_hit) begin
                            tbl_upd = 1'b1;
                            tbl_idx = core_idx;
                        end else if (!tbl_full) begin
                            tbl_upd   = 1'b1;
                            tbl_alloc = 1'b1;
                            tbl_idx   = free_idx;
                        end else if (ctl_d.pend == CAUSE_NONE) begin
                            ctl_d.pend = CAUSE_CAPACITY;
                        end
                    end
                end
                OP_END: begin
                    if (active) begin
                        if (ctl_q.depth == DEPTH_ONE) begin
                            ctl_d.depth = '0;
                            tbl_clear   = 1'b1;
                            if (ctl_d.pend != CAUSE_NONE) begin
                                ctl_d.abort = 1'b1;
                                ctl_d.cause = ctl_d.pend;
                            end else begin
                                ctl_d.commit = 1'b1;
                            end
                            ctl_d.pend = CAUSE_NONE;
                        end else begin
                            ctl_d.depth = ctl_q.depth - DEPTH_ONE;
                        end
                    end
                end
                OP_ABORT: begin
                    if (active) begin
                        ctl_d.depth = '0;
                        ctl_d.abort = 1'b1;
                        ctl_d.cause = CAUSE_EXPLICIT;
                        ctl_d.pend  = CAUSE_NONE;
                        tbl_clear   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.depth  <= '0;
            ctl_q.pend   <= CAUSE_NONE;
            ctl_q.commit <= 1'b0;
            ctl_q.abort  <= 1'b0;
            ctl_q.cause  <= CAUSE_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign txn_active_o  = active;
    assign nest_depth_o  = ctl_q.depth;
    assign commit_o      = ctl_q.commit;
    assign abort_o       = ctl_q.abort;
    assign abort_cause_o = ctl_q.cause;

endmodule

// File: rtl/txn_footprint_checker.sv
module txn_footprint_checker #(
    parameter int ADDR_W = 32,
    parameter int NEST_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_valid_i,
    input logic [2:0]        core_op_i,
    input logic [ADDR_W-1:0] core_addr_i,
    input logic              snoop_valid_i,
    input logic              snoop_write_i,
    input logic [ADDR_W-1:0] snoop_addr_i,
    input logic              txn_active_o,
    input logic [NEST_W-1:0] nest_depth_o,
    input logic              commit_o,
    input logic              abort_o,
    input logic [1:0]        abort_cause_o
);

    p_verdict_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o));

    p_commit_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> abort_cause_o == 2'd0);

    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> abort_cause_o != 2'd0);

    p_explicit_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active_o && core_valid_i && core_op_i == 3'd4)
        |=> (abort_o && abort_cause_o == 2'd3 && !txn_active_o));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_active_o && core_valid_i && core_op_i != 3'd0)
        |=> (!txn_active_o && !commit_o && !abort_o));

    p_inner_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid_i && core_op_i == 3'd3 && nest_depth_o > NEST_W'(1))
        |=> (!commit_o && !abort_o && nest_depth_o == $past(nest_depth_o) - NEST_W'(1)));

    p_outer_begin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_active_o && core_valid_i && core_op_i == 3'd0)
        |=> (nest_depth_o == NEST_W'(1)));

endmodule

bind txn_footprint_tracker txn_footprint_checker #(.ADDR_W(ADDR_W), .NEST_W(NEST_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_valid_i  (core_valid_i),
    .core_op_i     (core_op_i),
    .core_addr_i   (core_addr_i),
    .snoop_valid_i (snoop_valid_i),
    .snoop_write_i (snoop_write_i),
    .snoop_addr_i  (snoop_addr_i),
    .txn_active_o  (txn_active_o),
    .nest_depth_o  (nest_depth_o),
    .commit_o      (commit_o),
    .abort_o       (abort_o),
    .abort_cause_o (abort_cause_o)
);

// File: tb/test_txn_footprint_tracker.sv
module test_txn_footprint_tracker;

    localparam int CLK_P = 10;
    localparam logic [2:0] C_BEGIN = 3'd0, C_LOAD = 3'd1, C_STORE = 3'd2,
                           C_END = 3'd3, C_ABORT = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_valid_i = 1'b0;
    logic [2:0]  core_op_i = '0;
    logic [31:0] core_addr_i = '0;
    logic        snoop_valid_i = 1'b0;
    logic        snoop_write_i = 1'b0;
    logic [31:0] snoop_addr_i = '0;
    logic        txn_active_o, commit_o, abort_o;
    logic [2:0]  nest_depth_o;
    logic [1:0]  abort_cause_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    txn_footprint_tracker i_txn_footprint_tracker (
        .clk(clk), .rst_n(rst_n),
        .core_valid_i(core_valid_i), .core_op_i(core_op_i), .core_addr_i(core_addr_i),
        .snoop_valid_i(snoop_valid_i), .snoop_write_i(snoop_write_i), .snoop_addr_i(snoop_addr_i),
        .txn_active_o(txn_active_o), .nest_depth_o(nest_depth_o),
        .commit_o(commit_o), .abort_o(abort_o), .abort_cause_o(abort_cause_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic verdict(input string rq, input logic c, input logic a, input logic [1:0] cause);
        chk({rq, " commit"}, 32'(commit_o), 32'(c));
        chk({rq, " abort"},  32'(abort_o),  32'(a));
        chk({rq, " cause"},  32'(abort_cause_o), 32'(cause));
    endtask

    // Inputs change on the falling edge; outputs are read one falling edge later.
    task automatic step(input logic cv, input logic [2:0] op, input logic [31:0] a,
                        input logic sv, input logic sw, input logic [31:0] sa);
        core_valid_i = cv; core_op_i = op; core_addr_i = a;
        snoop_valid_i = sv; snoop_write_i = sw; snoop_addr_i = sa;
        @(posedge clk);
        @(negedge clk);
        core_valid_i = 1'b0;
        snoop_valid_i = 1'b0;
    endtask

    task automatic core(input logic [2:0] op, input logic [31:0] a);
        step(1'b1, op, a, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic snp(input logic w, input logic [31:0] a);
        step(1'b0, 3'd0, 32'h0, 1'b1, w, a);
    endtask

    task automatic t_reset;
        chk("R1 active", 32'(txn_active_o), 0);
        chk("R1 depth", 32'(nest_depth_o), 0);
        verdict("R1", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_commit;
        core(C_BEGIN, 0);
        chk("R9 begin depth", 32'(nest_depth_o), 1);
        core(C_LOAD, 32'h1000);
        core(C_STORE, 32'h2040);
        core(C_END, 0);
        verdict("R5 plain commit", 1'b1, 1'b0, 2'd0);
        chk("R5 inactive after", 32'(txn_active_o), 0);
        core(3'd6, 0);
        verdict("R5 pulse one cycle", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_read_set;
        core(C_BEGIN, 0);
        core(C_LOAD, 32'h1000);
        snp(1'b1, 32'h1008);
        verdict("R3 no early verdict", 1'b0, 1'b0, 2'd0);
        chk("R3 still active", 32'(txn_active_o), 1);
        core(C_END, 0);
        verdict("R3 R2 write same line", 1'b0, 1'b1, 2'd1);
    endtask

    task automatic t_write_set;
        core(C_BEGIN, 0);
        core(C_STORE, 32'h3000);
        snp(1'b0, 32'h303C);
        core(C_END, 0);
        verdict("R4 read of written line", 1'b0, 1'b1, 2'd1);
        core(C_BEGIN, 0);
        core(C_STORE, 32'h3000);
        snp(1'b1, 32'h3000);
        core(C_END, 0);
        verdict("R4 write of written line", 1'b0, 1'b1, 2'd1);
        core(C_BEGIN, 0);
        core(C_LOAD, 32'h3000);
        snp(1'b0, 32'h3000);
        core(C_END, 0);
        verdict("R4 read of read line", 1'b1, 1'b0, 2'd0);
    endtask

    task automatic t_capacity;
        core(C_BEGIN, 0);
        for (int i = 0; i < 8; i++) core(C_LOAD, 32'h10000 + 32'(i) * 64);
        core(C_STORE, 32'h1003F);
        core(C_LOAD, 32'h101C1);
        core(C_END, 0);
        verdict("R6 R2 eight lines fit", 1'b1, 1'b0, 2'd0);
        core(C_BEGIN, 0);
        for (int i = 0; i < 9; i++) core(C_STORE, 32'h20000 + 32'(i) * 64);
        core(C_END, 0);
        verdict("R6 ninth line", 1'b0, 1'b1, 2'd2);
    endtask

    task automatic t_explicit;
        core(C_BEGIN, 0);
        core(C_BEGIN, 0);
        core(C_ABORT, 0);
        verdict("R7 explicit", 1'b0, 1'b1, 2'd3);
        chk("R7 inactive", 32'(txn_active_o), 0);
        chk("R7 depth", 32'(nest_depth_o), 0);
    endtask

    task automatic t_idle;
        core(C_LOAD, 32'h5000);
        verdict("R8 idle load", 1'b0, 1'b0, 2'd0);
        core(C_STORE, 32'h5000);
        core(C_END, 0);
        verdict("R8 idle end", 1'b0, 1'b0, 2'd0);
        core(C_ABORT, 0);
        verdict("R8 idle abort", 1'b0, 1'b0, 2'd0);
        chk("R8 idle active", 32'(txn_active_o), 0);
        core(C_BEGIN, 0);
        snp(1'b1, 32'h5000);
        core(C_END, 0);
        verdict("R8 idle line untracked", 1'b1, 1'b0, 2'd0);
    endtask

    task automatic t_nest;
        core(C_BEGIN, 0);
        core(C_BEGIN, 0);
        chk("R9 depth two", 32'(nest_depth_o), 2);
        core(C_LOAD, 32'h6000);
        core(C_END, 0);
        verdict("R9 inner end", 1'b0, 1'b0, 2'd0);
        chk("R9 depth back", 32'(nest_depth_o), 1);
        snp(1'b1, 32'h6000);
        core(C_END, 0);
        verdict("R9 outer end", 1'b0, 1'b1, 2'd1);
        for (int i = 0; i < 8; i++) core(C_BEGIN, 0);
        chk("R9 saturate", 32'(nest_depth_o), 7);
        for (int i = 0; i < 6; i++) core(C_END, 0);
        verdict("R9 before last end", 1'b0, 1'b0, 2'd0);
        core(C_END, 0);
        verdict("R9 last end", 1'b1, 1'b0, 2'd0);
    endtask

    task automatic t_clear;
        core(C_BEGIN, 0);
        core(C_STORE, 32'h7000);
        core(C_END, 0);
        verdict("R10 first", 1'b1, 1'b0, 2'd0);
        core(C_BEGIN, 0);
        snp(1'b1, 32'h7000);
        core(C_END, 0);
        verdict("R10 cleared", 1'b1, 1'b0, 2'd0);
    endtask

    task automatic t_same_cycle;
        core(C_BEGIN, 0);
        step(1'b1, C_LOAD, 32'h8000, 1'b1, 1'b1, 32'h8000);
        core(C_END, 0);
        verdict("R11 snoop before insert", 1'b1, 1'b0, 2'd0);
        core(C_BEGIN, 0);
        core(C_LOAD, 32'h8000);
        step(1'b1, C_END, 0, 1'b1, 1'b1, 32'h8010);
        verdict("R11 snoop with end", 1'b0, 1'b1, 2'd1);
        core(C_BEGIN, 0);
        core(C_LOAD, 32'h9000);
        snp(1'b1, 32'h9000);
        for (int i = 1; i < 10; i++) core(C_LOAD, 32'h9000 + 32'(i) * 64);
        core(C_END, 0);
        verdict("R11 first cause kept", 1'b0, 1'b1, 2'd1);
    endtask

    task automatic t_untracked;
        core(C_BEGIN, 0);
        core(C_STORE, 32'hA000);
        snp(1'b1, 32'hA040);
        snp(1'b0, 32'hB000);
        core(C_END, 0);
        verdict("R12 other lines", 1'b1, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit();
        t_read_set();
        t_write_set();
        t_capacity();
        t_explicit();
        t_idle();
        t_nest();
        t_clear();
        t_same_cycle();
        t_untracked();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule